// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers words between two unrelated clock domains. A producer pushes words on the write clock and a consumer pulls them on the read clock. Each side has its own active-low enable. Five active-low status flags report the fill level: full, almost-full, half-full, almost-empty and empty. The almost-full and almost-empty thresholds come from two offset registers. Software-free setup is done through the data path: while a shared load strobe is held low, write-side accesses program the offsets and read-side accesses return them on the data output. Each side steps through the two registers in a fixed alternation, empty offset first.

The stream rules are as follows. The write enable acts as "valid" and a high full flag acts as "ready", so a word is taken only on an edge where both hold. On the read side the read enable acts as the request and a high empty flag is the grant. The fetched word appears on the data output after that read-clock edge and holds until the next accepted read. Pointers cross between the domains in gray code through a configurable synchronizer chain. Each side therefore sees the other's progress a little late, and this only ever makes the flags err towards caution.

Top module: `dcf_fifo_top`

## Requirements
- R1: While rst_n is low and after its release with no traffic: full_n=1, afull_n=1, half_n=1, empty_n=0, aempty_n=0, q=0, and both offset access orders restart at the empty offset.
- R2: With load_n=1, a word on din is stored on a rising wclk when wen_n=0 and full_n=1. Words come out on q in the order they were stored, with none lost or repeated.
- R3: A write attempted while full_n=0 stores nothing and does not move the write pointer. The FIFO contents stay exactly the first DEPTH words.
- R4: A read attempted while empty_n=0 leaves q unchanged and does not move the read pointer.
- R5: empty_n is 0 exactly when 0 words are held. full_n is 0 exactly when DEPTH words are held.
- R6: aempty_n is 0 while the word count is at most the empty offset y.
- R7: afull_n is 0 while the word count is at least DEPTH minus the full offset x.
- R8: half_n is 0 while the word count is at least DEPTH/2+1.
- R9: With load_n=0 and wen_n=0, successive wclk edges store din[log2(DEPTH)-1:0] into y, then into x, then into y again, and so on. The upper din bits are ignored and the memory is untouched.
- R10: With load_n=0 and ren_n=0, successive rclk edges put y, then x, then y again (zero-extended) on q. No memory word is consumed.
- R11: Reset restores both offsets to min(DEPTH/8-1, 127), which is 31 for DEPTH=256.
- R12: After a word is written into an empty FIFO, empty_n rises no earlier than the first and no later than the second rising rclk edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wen_n | input | 1 | Active-low write request (valid) |
| ren_n | input | 1 | Active-low read request |
| load_n | input | 1 | Active-low strobe that redirects accesses to the offset registers |
| din | input | DATA_W | Write data; low bits carry offsets under load |
| q | output | DATA_W | Read data or offset readback |
| full_n | output | 1 | Low when DEPTH words are held (write ready when high) |
| afull_n | output | 1 | Low at or above DEPTH minus full offset |
| half_n | output | 1 | Low above half depth |
| aempty_n | output | 1 | Low at or below the empty offset |
| empty_n | output | 1 | Low when no word is held (read grant when high) |

## Verification
The data path is exercised in three patterns. Single words into an empty FIFO expose the synchronizer latency. A monotonic fill to full and past it separates each flag threshold and shows whether extra writes are dropped or overwrite data. Concurrent bursts on two clocks of different rates show whether the gray crossing loses or duplicates words under back-pressure from both sides. The offset path is tried with repeated loads that carry garbage in the upper data bits and with readbacks of odd and even length. These distinguish a correct alternation from a stuck or reversed one. A reset in mid-traffic then shows that both the pointers and the register defaults return.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic {
    SEL_EMPTY_OFS = 1'b0,
    SEL_FULL_OFS  = 1'b1
  } ofs_sel_e;

  function automatic int unsigned dflt_offset(input int unsigned depth);
    if (depth >= 1024) return 127;
    else if (depth >= 8) return depth / 8 - 1;
    else return 0;
  endfunction

endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] ram [WORDS];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wen_n,
  input  logic          load_n,
  input  logic [AW-1:0] cfg_in,
  input  logic [AW:0]   rgray_sync,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] ofs_empty,
  output logic [AW-1:0] ofs_full,
  output logic          full_n,
  output logic          afull_n,
  output logic          half_n
);
  localparam logic [AW:0]   DEPTH_V = (AW+1)'(DEPTH);
  localparam logic [AW:0]   HALF_V  = (AW+1)'(DEPTH / 2);
  localparam logic [AW-1:0] DFLT    = AW'(dflt_offset(DEPTH));

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] wbin, wbin_nx, rbin_s, wcount;
  logic        is_full, push, ofs_wr;
  ofs_sel_e    wsel;

  assign rbin_s  = g2b(rgray_sync);
  assign wcount  = wbin - rbin_s;
  assign is_full = (wcount == DEPTH_V);
  assign push    = !wen_n && load_n && !is_full;
  assign ofs_wr  = !wen_n && !load_n;
  assign wbin_nx = wbin + 1'b1;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin      <= '0;
      wgray     <= '0;
      ofs_empty <= DFLT;
      ofs_full  <= DFLT;
      wsel      <= SEL_EMPTY_OFS;
    end else begin
      if (push) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      if (ofs_wr) begin
        if (wsel == SEL_EMPTY_OFS) ofs_empty <= cfg_in;
        else                       ofs_full  <= cfg_in;
        wsel <= (wsel == SEL_EMPTY_OFS) ? SEL_FULL_OFS : SEL_EMPTY_OFS;
      end
    end
  end

  assign mem_we    = push;
  assign mem_waddr = wbin[AW-1:0];
  assign full_n    = !is_full;
  assign afull_n   = !(wcount >= (DEPTH_V - {1'b0, ofs_full}));
  assign half_n    = !(wcount > HALF_V);

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n && !wen_n && load_n) |=> $stable(wbin));

  assert_cfg_write_keeps_ptr_R9: assert property (@(posedge wclk) disable iff (!rst_n)
    (!load_n && !wen_n) |=> $stable(wbin));

  assert_count_bound_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= DEPTH_V);

  assert_full_implies_upper_flags_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> (!afull_n && !half_n));
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int DW    = 18,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ren_n,
  input  logic          load_n,
  input  logic [AW:0]   wgray_sync,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] ofs_empty,
  input  logic [AW-1:0] ofs_full,
  output logic [AW-1:0] mem_raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] q,
  output logic          empty_n,
  output logic          aempty_n
);
  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] rbin, rbin_nx, wbin_s, rcount;
  logic        is_empty, pop, ofs_rd;
  ofs_sel_e    rsel;

  assign wbin_s   = g2b(wgray_sync);
  assign rcount   = wbin_s - rbin;
  assign is_empty = (rcount == '0);
  assign pop      = !ren_n && load_n && !is_empty;
  assign ofs_rd   = !ren_n && !load_n;
  assign rbin_nx  = rbin + 1'b1;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      q     <= '0;
      rsel  <= SEL_EMPTY_OFS;
    end else begin
      if (pop) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
        q     <= mem_rdata;
      end
      if (ofs_rd) begin
        q    <= (rsel == SEL_EMPTY_OFS) ? DW'(ofs_empty) : DW'(ofs_full);
        rsel <= (rsel == SEL_EMPTY_OFS) ? SEL_FULL_OFS : SEL_EMPTY_OFS;
      end
    end
  end

  assign mem_raddr = rbin[AW-1:0];
  assign empty_n   = !is_empty;
  assign aempty_n  = !(rcount <= {1'b0, ofs_empty});

  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n && !ren_n && load_n) |=> $stable(rbin));

  assert_q_hold_on_empty_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n && !ren_n && load_n) |=> $stable(q));

  assert_cfg_read_keeps_ptr_R10: assert property (@(posedge rclk) disable iff (!rst_n)
    (!load_n && !ren_n) |=> $stable(rbin));

  assert_empty_implies_aempty_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
endmodule

// File: rtl/dcf_fifo_top.sv
module dcf_fifo_top #(
  parameter int DATA_W      = 18,
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wen_n,
  input  logic              ren_n,
  input  logic              load_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q,
  output logic              full_n,
  output logic              afull_n,
  output logic              half_n,
  output logic              aempty_n,
  output logic              empty_n
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]     wgray, rgray, wgray_s, rgray_s;
  logic            mem_we;
  logic [AW-1:0]   waddr, raddr, ofs_empty, ofs_full;
  logic [DATA_W-1:0] rdata;

  dcf_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wen_n(wen_n), .load_n(load_n),
    .cfg_in(din[AW-1:0]), .rgray_sync(rgray_s),
    .mem_we(mem_we), .mem_waddr(waddr), .wgray(wgray),
    .ofs_empty(ofs_empty), .ofs_full(ofs_full),
    .full_n(full_n), .afull_n(afull_n), .half_n(half_n)
  );

  dcf_gray_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  dcf_gray_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  dcf_mem #(.DW(DATA_W), .AW(AW)) u_mem (
    .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(din),
    .raddr(raddr), .rdata(rdata)
  );

  dcf_rd_ctrl #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .load_n(load_n),
    .wgray_sync(wgray_s), .mem_rdata(rdata),
    .ofs_empty(ofs_empty), .ofs_full(ofs_full),
    .mem_raddr(raddr), .rgray(rgray), .q(q),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );
endmodule

// File: tb/sim_dcf_fifo_top.sv
module sim_dcf_fifo_top;
  localparam int DW = 18;
  localparam int D  = 256;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wen_n = 1, ren_n = 1, load_n = 1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] q;
  logic full_n, afull_n, half_n, aempty_n, empty_n;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] exp_q [$];

  always #10 wclk = ~wclk;
  always #13 rclk = ~rclk;

  dcf_fifo_top u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .ren_n(ren_n),
    .load_n(load_n), .din(din), .q(q), .full_n(full_n), .afull_n(afull_n),
    .half_n(half_n), .aempty_n(aempty_n), .empty_n(empty_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  // Driver: pushes each accepted word into the scoreboard.
  task automatic wr_burst(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      load_n = 1; wen_n = 0; din = DW'(base + i);
      if (full_n) exp_q.push_back(DW'(base + i));
    end
    @(negedge wclk);
    wen_n = 1;
  endtask

  // Monitor: pops and compares each word the design delivers.
  task automatic rd_burst(input int n, output int got);
    bit pend = 0;
    logic [DW-1:0] e;
    got = 0;
    for (int i = 0; i <= n; i++) begin
      @(negedge rclk);
      if (pend) begin
        got++;
        if (exp_q.size() == 0) begin
          chk("R2 unexpected word", int'(q), -1);
        end else begin
          e = exp_q.pop_front();
          chk("R2 order", int'(q), int'(e));
        end
      end
      if (i < n) begin
        load_n = 1; ren_n = 0; pend = empty_n;
      end else begin
        ren_n = 1; pend = 0;
      end
    end
  endtask

  task automatic cfg_write(input logic [DW-1:0] v);
    @(negedge wclk);
    load_n = 0; wen_n = 0; din = v;
    @(negedge wclk);
    wen_n = 1; load_n = 1;
  endtask

  task automatic cfg_read(output int v);
    @(negedge rclk);
    load_n = 0; ren_n = 0;
    @(negedge rclk);
    ren_n = 1; load_n = 1;
    v = int'(q);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, got, cnt;
    #95;
    // R1 during reset
    chk("R1 full_n", full_n, 1);   chk("R1 afull_n", afull_n, 1);
    chk("R1 half_n", half_n, 1);   chk("R1 empty_n", empty_n, 0);
    chk("R1 aempty_n", aempty_n, 0); chk("R1 q", int'(q), 0);
    @(negedge wclk); rst_n = 1;
    settle();
    chk("R1 empty_n after release", empty_n, 0);

    // R11 defaults
    cfg_read(v); chk("R11 default y", v, 31);
    cfg_read(v); chk("R11 default x", v, 31);

    // R9 writes: y then x, upper bits ignored
    cfg_write(18'h3FF05);
    cfg_write(18'h2A00A);
    settle();
    chk("R9 memory untouched", empty_n, 0);
    // R10 readback alternation
    cfg_read(v); chk("R10 first y", v, 5);
    cfg_read(v); chk("R10 then x", v, 10);
    cfg_read(v); chk("R10 repeat y", v, 5);
    cfg_read(v); chk("R10 repeat x", v, 10);
    chk("R10 no word consumed", empty_n, 0);

    // R4 read on empty holds q
    @(negedge rclk); load_n = 1; ren_n = 0;
    @(negedge rclk); ren_n = 1;
    chk("R4 q held on empty read", int'(q), 10);

    // R12 latency into empty FIFO
    @(negedge wclk); wen_n = 0; din = 18'h01111; exp_q.push_back(18'h01111);
    @(posedge wclk); #1 wen_n = 1;
    chk("R12 not visible at write edge", empty_n, 0);
    cnt = 0;
    while (!empty_n && cnt < 5) begin
      @(posedge rclk); #1; cnt++;
    end
    chk("R12 visible within two read edges", int'(cnt >= 1 && cnt <= 2), 1);
    rd_burst(1, got); chk("R4 word after empty read", got, 1);
    settle();

    // Fill with flag thresholds (y=5, x=10)
    wr_burst(5, 100); settle();
    chk("R5 empty_n with 5", empty_n, 1);
    chk("R6 aempty_n at y", aempty_n, 0);
    wr_burst(1, 105); settle();
    chk("R6 aempty_n at y+1", aempty_n, 1);
    wr_burst(122, 106); settle();
    chk("R8 half_n at D/2", half_n, 1);
    wr_burst(1, 228); settle();
    chk("R8 half_n at D/2+1", half_n, 0);
    wr_burst(116, 229); settle();
    chk("R7 afull_n at D-x-1", afull_n, 1);
    wr_burst(1, 345); settle();
    chk("R7 afull_n at D-x", afull_n, 0);
    wr_burst(9, 346); settle();
    chk("R5 full_n at D-1", full_n, 1);
    wr_burst(1, 355); settle();
    chk("R5 full_n at D", full_n, 0);
    wr_burst(4, 900); settle();
    chk("R3 still full", full_n, 0);
    chk("R3 scoreboard holds D", exp_q.size(), D);

    // Drain: exactly the first D words
    rd_burst(D + 4, got);
    chk("R3 words drained", got, D);
    settle();
    chk("R5 empty_n after drain", empty_n, 0);
    chk("R6 aempty_n after drain", aempty_n, 0);
    chk("R8 half_n after drain", half_n, 1);
    chk("R7 afull_n after drain", afull_n, 1);
    chk("R5 full_n after drain", full_n, 1);

    // Concurrent streaming on both clocks
    fork
      wr_burst(300, 5000);
      rd_burst(330, got);
    join
    settle();
    rd_burst(D, got);
    chk("R2 stream fully delivered", exp_q.size(), 0);

    // Reset mid-traffic
    wr_burst(3, 7000);
    cfg_write(18'h00007);
    @(negedge wclk); rst_n = 0;
    #60;
    chk("R1 q cleared", int'(q), 0);
    chk("R1 empty_n on reset", empty_n, 0);
    @(negedge wclk); rst_n = 1;
    exp_q.delete();
    settle();
    chk("R1 full_n after reset", full_n, 1);
    cfg_read(v); chk("R11 y restored", v, 31);
    cfg_read(v); chk("R11 x restored", v, 31);
    cfg_write(18'h00003);
    cfg_read(v); chk("R1 write order restarts at y", v, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule